// File: doc/BRIEF.md
# Spectrum Frame Stream Controller

This block sits around a fixed-length transform-and-magnitude engine and handles all of its stream control. On the receive side it takes a radio sample stream with valid, last and end-of-burst flags. It throttles that stream with a ready signal, counts samples into frames of `FRAME_LEN`, and forwards each accepted sample to the engine. When a frame completes, it starts the engine. When a burst ends in the middle of a frame, it tells the engine to drop the partial frame. The engine sits outside this block; the bench stands in for it with a latency model.

On the output side the controller takes the engine's bin magnitudes and turns each one into a 32-bit word with a start-of-frame flag. It drives valid, last and end-of-burst toward a memory buffer and honours that buffer's ready. A process-enable input gates all activity. Dropping the enable clears the frame state, resets the engine and marks the output stream as ended, so that stale data cannot leak into a later run.

Top module: `spec_frame_ctrl`

## Requirements
- R1: `rx_ready` is high only when `proc_en` is high, `out_ready` is high, and the controller is collecting a frame (not waiting on results).
- R2: Once `FRAME_LEN` samples of a frame have been accepted, `rx_ready` is low from the next cycle. It stays low until the last of that frame's `FRAME_LEN` output words has been loaded into the output register, and then returns high.
- R3: Each accepted sample (except a discarded one) appears on `eng_data` with `eng_valid` one cycle after acceptance, in order. `eng_go` pulses together with the frame's final sample.
- R4: A sample with both `rx_eob` and `rx_last` high that arrives before a frame is complete discards that sample and the partial frame: it is not forwarded, `eng_flush` pulses on the next cycle, and counting restarts at zero. The same flags on a frame's final sample complete the frame normally.
- R5: While `proc_en` is low, the frame state is cleared and `eng_flush` is high. On the cycle after any low-enable cycle, `out_eob` is high and `out_valid` is low.
- R6: Output word layout: bits 16:0 carry the 17-bit signed magnitude. Bit 31 is 1 only on bin 0 of each frame. Bits 30:17 are zero.
- R7: `out_valid` is high only after a magnitude was taken from the engine in a cycle with `proc_en` high, and it drops on the cycle after `proc_en` goes low.
- R8: `out_last` is high on every 256th output word (bins 255, 511, …) and on the final bin of each frame.
- R9: `out_eob` is high on the final bin (`FRAME_LEN-1`) of each frame and on no other valid word while enabled. Any word with `out_eob` also has `out_last`.
- R10: While `out_valid` is high and `out_ready` is low, `out_word` holds its value. The engine's `mag_ready` is high only when `proc_en` is high, results are awaited, and the output register is free or draining.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| proc_en | input | 1 | Process-enable control |
| rx_data | input | 32 | Received complex sample |
| rx_valid | input | 1 | Sample valid |
| rx_last | input | 1 | Final sample of a packet |
| rx_eob | input | 1 | High for the whole final packet of a burst |
| rx_ready | output | 1 | Back-pressure toward the radio |
| eng_data | output | 32 | Sample forwarded to the engine |
| eng_valid | output | 1 | Forwarded sample valid |
| eng_go | output | 1 | Frame complete, start processing |
| eng_flush | output | 1 | Reset engine / drop partial frame |
| mag_data | input | 17 | Bin magnitude from engine |
| mag_valid | input | 1 | Magnitude valid |
| mag_ready | output | 1 | Controller accepts magnitude |
| out_word | output | 32 | Packed output word |
| out_valid | output | 1 | Output word valid |
| out_last | output | 1 | End of output packet |
| out_eob | output | 1 | End of output burst |
| out_ready | input | 1 | Memory buffer can accept |

## Verification
The assertions check several rules on every cycle. Back-pressure must hold while a frame awaits results. Every accepted sample must be forwarded, and a cut-off frame must always be followed by a flush. Output-word zero bits, end-of-burst implying last, and hold-under-stall are also checked, as is the forced end-of-burst after any disabled cycle. Other behaviours can only be shown by the bench's scenarios, through its engine model. These are: bin-to-sample ordering, the start flag on exactly bin 0, the last cadence, discarding a partial burst so that the next frame's results are clean, and return to ready after the final bin.

// File: rtl/sfsc_pkg.sv
package sfsc_pkg;
  typedef enum logic {ST_FILL = 1'b0, ST_WAIT = 1'b1} fill_st_e;
  localparam int WORD_W = 32;
endpackage

// File: rtl/sfsc_rx_gate.sv
module sfsc_rx_gate import sfsc_pkg::*; #(
  parameter int FRAME_LEN = 2048,
  parameter int IN_W      = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            proc_en,
  input  logic            down_rdy,
  input  logic [IN_W-1:0] rx_data,
  input  logic            rx_valid,
  input  logic            rx_last,
  input  logic            rx_eob,
  output logic            rx_ready,
  input  logic            frame_done,
  output logic            busy,
  output logic [IN_W-1:0] eng_data,
  output logic            eng_valid,
  output logic            eng_go,
  output logic            eng_flush
);
  localparam int CNT_W = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_LEN - 1);

  fill_st_e         st;
  logic [CNT_W-1:0] cnt;
  logic             fire, cnt_end, discard;

  assign busy     = (st == ST_WAIT);
  assign rx_ready = proc_en && down_rdy && (st == ST_FILL);
  assign fire     = rx_valid && rx_ready;
  assign cnt_end  = (cnt == CNT_LAST);
  assign discard  = fire && rx_eob && rx_last && !cnt_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_FILL;
      cnt       <= '0;
      eng_data  <= '0;
      eng_valid <= 1'b0;
      eng_go    <= 1'b0;
      eng_flush <= 1'b0;
    end else begin
      eng_valid <= 1'b0;
      eng_go    <= 1'b0;
      eng_flush <= !proc_en;
      if (!proc_en) begin
        st  <= ST_FILL;
        cnt <= '0;
      end else if (st == ST_WAIT) begin
        if (frame_done) st <= ST_FILL;
      end else if (discard) begin
        cnt       <= '0;
        eng_flush <= 1'b1;
      end else if (fire) begin
        eng_valid <= 1'b1;
        eng_data  <= rx_data;
        if (cnt_end) begin
          cnt    <= '0;
          st     <= ST_WAIT;
          eng_go <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  AST_WAIT_STALLS: assert property (@(posedge clk) disable iff (rst)
    (busy && !frame_done && proc_en) |=> !rx_ready);                      // R2
  AST_GO_WITH_DATA: assert property (@(posedge clk) disable iff (rst)
    eng_go |-> (eng_valid && !eng_flush));                                 // R3
  AST_ACCEPT_FWD: assert property (@(posedge clk) disable iff (rst)
    (fire && !discard) |=> eng_valid);                                     // R3
  AST_DISCARD_FLUSH: assert property (@(posedge clk) disable iff (rst)
    discard |=> (eng_flush && !eng_valid && !eng_go));                     // R4
  AST_DISABLE_FLUSH: assert property (@(posedge clk) disable iff (rst)
    !proc_en |=> eng_flush);                                               // R5
endmodule

// File: rtl/sfsc_out_fmt.sv
module sfsc_out_fmt import sfsc_pkg::*; #(
  parameter int FRAME_LEN = 2048,
  parameter int PKT_LEN   = 256,
  parameter int MAG_W     = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              proc_en,
  input  logic              busy,
  input  logic [MAG_W-1:0]  mag_data,
  input  logic              mag_valid,
  output logic              mag_ready,
  output logic              frame_done,
  output logic [WORD_W-1:0] out_word,
  output logic              out_valid,
  output logic              out_last,
  output logic              out_eob,
  input  logic              out_ready
);
  localparam int BIN_W = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;
  localparam int PKT_W = (PKT_LEN > 1) ? $clog2(PKT_LEN) : 1;
  localparam logic [BIN_W-1:0] BIN_LAST = BIN_W'(FRAME_LEN - 1);
  localparam logic [PKT_W-1:0] PKT_LAST = PKT_W'(PKT_LEN - 1);

  logic [BIN_W-1:0]  bin_cnt;
  logic [PKT_W-1:0]  pkt_cnt;
  logic              mag_fire, bin_end, pkt_end;
  logic [WORD_W-1:0] nxt_word;

  assign mag_ready  = proc_en && busy && (!out_valid || out_ready);
  assign mag_fire   = mag_valid && mag_ready;
  assign bin_end    = (bin_cnt == BIN_LAST);
  assign pkt_end    = (pkt_cnt == PKT_LAST);
  assign frame_done = mag_fire && bin_end;

  always_comb begin
    nxt_word              = '0;
    nxt_word[MAG_W-1:0]   = mag_data;
    nxt_word[WORD_W-1]    = (bin_cnt == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_word  <= '0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_eob   <= 1'b0;
      bin_cnt   <= '0;
      pkt_cnt   <= '0;
    end else if (!proc_en) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_eob   <= 1'b1;
      bin_cnt   <= '0;
      pkt_cnt   <= '0;
    end else if (mag_fire) begin
      out_word  <= nxt_word;
      out_valid <= 1'b1;
      out_last  <= pkt_end || bin_end;
      out_eob   <= bin_end;
      bin_cnt   <= bin_end ? '0 : bin_cnt + 1'b1;
      pkt_cnt   <= (pkt_end || bin_end) ? '0 : pkt_cnt + 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_eob   <= 1'b0;
    end
  end

  AST_EOB_ON_DISABLE: assert property (@(posedge clk) disable iff (rst)
    !proc_en |=> (out_eob && !out_valid));                                 // R5
  AST_WORD_ZERO_BITS: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_word[WORD_W-2:MAG_W] == '0));                       // R6
  AST_VALID_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(proc_en));                                         // R7
  AST_EOB_HAS_LAST: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_eob) |-> out_last);                                  // R9
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> $stable(out_word));                      // R10
endmodule

// File: rtl/spec_frame_ctrl.sv
module spec_frame_ctrl import sfsc_pkg::*; #(
  parameter int FRAME_LEN = 2048,
  parameter int PKT_LEN   = 256,
  parameter int MAG_W     = 17,
  parameter int IN_W      = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              proc_en,
  input  logic [IN_W-1:0]   rx_data,
  input  logic              rx_valid,
  input  logic              rx_last,
  input  logic              rx_eob,
  output logic              rx_ready,
  output logic [IN_W-1:0]   eng_data,
  output logic              eng_valid,
  output logic              eng_go,
  output logic              eng_flush,
  input  logic [MAG_W-1:0]  mag_data,
  input  logic              mag_valid,
  output logic              mag_ready,
  output logic [WORD_W-1:0] out_word,
  output logic              out_valid,
  output logic              out_last,
  output logic              out_eob,
  input  logic              out_ready
);
  logic busy, frame_done;

  sfsc_rx_gate #(.FRAME_LEN(FRAME_LEN), .IN_W(IN_W)) u_rx (
    .clk(clk), .rst(rst), .proc_en(proc_en), .down_rdy(out_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_last(rx_last),
    .rx_eob(rx_eob), .rx_ready(rx_ready), .frame_done(frame_done),
    .busy(busy), .eng_data(eng_data), .eng_valid(eng_valid),
    .eng_go(eng_go), .eng_flush(eng_flush)
  );

  sfsc_out_fmt #(.FRAME_LEN(FRAME_LEN), .PKT_LEN(PKT_LEN), .MAG_W(MAG_W)) u_out (
    .clk(clk), .rst(rst), .proc_en(proc_en), .busy(busy),
    .mag_data(mag_data), .mag_valid(mag_valid), .mag_ready(mag_ready),
    .frame_done(frame_done), .out_word(out_word), .out_valid(out_valid),
    .out_last(out_last), .out_eob(out_eob), .out_ready(out_ready)
  );
endmodule

// File: tb/spec_frame_ctrl_tb_top.sv
`timescale 1ns/1ps
module spec_frame_ctrl_tb_top;
  localparam int FL  = 2048;
  localparam int PL  = 256;
  localparam int LAT = 16;

  logic clk = 0, rst = 1, proc_en = 0;
  logic [31:0] rx_data = '0;
  logic rx_valid = 0, rx_last = 0, rx_eob = 0, rx_ready;
  logic [31:0] eng_data;
  logic eng_valid, eng_go, eng_flush;
  logic [16:0] mag_data;
  logic mag_valid, mag_ready;
  logic [31:0] out_word;
  logic out_valid, out_last, out_eob;
  logic out_ready = 1;

  always #10 clk = ~clk;

  spec_frame_ctrl dut_i (
    .clk(clk), .rst(rst), .proc_en(proc_en), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_last(rx_last), .rx_eob(rx_eob), .rx_ready(rx_ready),
    .eng_data(eng_data), .eng_valid(eng_valid), .eng_go(eng_go), .eng_flush(eng_flush),
    .mag_data(mag_data), .mag_valid(mag_valid), .mag_ready(mag_ready),
    .out_word(out_word), .out_valid(out_valid), .out_last(out_last),
    .out_eob(out_eob), .out_ready(out_ready)
  );

  // Engine stand-in: stores forwarded samples, replays low 17 bits as bins
  logic [16:0] emem [FL];
  int wr_i, rd_i, lat_c;
  logic run;
  always @(posedge clk) begin
    if (rst || eng_flush) begin
      wr_i <= 0; rd_i <= 0; lat_c <= 0; run <= 0;
    end else begin
      if (eng_valid && wr_i < FL) begin emem[wr_i] <= eng_data[16:0]; wr_i <= wr_i + 1; end
      if (eng_go) begin lat_c <= LAT; wr_i <= 0; end
      else if (lat_c > 0) begin
        lat_c <= lat_c - 1;
        if (lat_c == 1) begin run <= 1; rd_i <= 0; end
      end
      if (run && mag_ready) begin
        if (rd_i == FL-1) run <= 0;
        rd_i <= rd_i + 1;
      end
    end
  end
  assign mag_valid = run;
  assign mag_data  = (run && rd_i < FL) ? emem[rd_i] : '0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [16:0] pat(input int tag, input int i);
    return 17'((tag * 1237 + i * 29) & 32'h1FFFF);
  endfunction

  // Output monitor
  logic [31:0] got_w [FL+8];
  bit got_l [FL+8];
  bit got_e [FL+8];
  int ocnt = 0, hold_bad = 0, r1_bad = 0;
  bit bp_on = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [31:0] prev_w = '0;
  bit prev_hold = 0;
  always @(negedge clk) begin
    if (bp_on) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = lfsr[0] | lfsr[3];
    end
    #2;
    if (!rst) begin
      if (rx_ready && (!out_ready || !proc_en)) r1_bad++;
      if (prev_hold && out_word != prev_w) hold_bad++;
      prev_hold = out_valid && !out_ready;
      prev_w = out_word;
      if (out_valid && out_ready && ocnt < FL+8) begin
        got_w[ocnt] = out_word; got_l[ocnt] = out_last; got_e[ocnt] = out_eob;
        ocnt++;
      end
    end
  end

  task automatic send(input int n, input int tag, input bit eob_end);
    int pk_start;
    pk_start = ((n - 1) / PL) * PL;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 1;
      rx_data  = {15'h0, pat(tag, i)};
      rx_last  = ((i % PL) == PL-1) || (i == n-1);
      rx_eob   = eob_end && (i >= pk_start);
      #1;
      while (!rx_ready) begin @(negedge clk); #1; end
    end
    @(negedge clk);
    rx_valid = 0; rx_last = 0; rx_eob = 0;
  endtask

  task automatic check_frame(input int tag, input string nm);
    int bad_d, bad_f, bad_l, bad_e, t;
    bad_d = 0; bad_f = 0; bad_l = 0; bad_e = 0; t = 0;
    while (ocnt < FL && t < 40000) begin @(negedge clk); t++; end
    chk(ocnt == FL, {"R3 word count ", nm}, ocnt, FL);
    for (int k = 0; k < FL && k < ocnt; k++) begin
      if (got_w[k][16:0] != pat(tag, k) || got_w[k][30:17] != 0) bad_d++;
      if (got_w[k][31] != (k == 0)) bad_f++;
      if (got_l[k] != (((k % PL) == PL-1) || k == FL-1)) bad_l++;
      if (got_e[k] != (k == FL-1)) bad_e++;
    end
    chk(bad_d == 0, {"R6 magnitude/zero bits ", nm}, bad_d, 0);
    chk(bad_f == 0, {"R6 start flag bit31 ", nm}, bad_f, 0);
    chk(bad_l == 0, {"R8 last cadence ", nm}, bad_l, 0);
    chk(bad_e == 0, {"R9 eob on final bin ", nm}, bad_e, 0);
    repeat (3) @(negedge clk);
    #3;
    chk(rx_ready == out_ready, {"R2 ready returns after final bin ", nm}, rx_ready, out_ready);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    #3;
    chk(rx_ready == 0, "R1 ready low while disabled", rx_ready, 0);
    chk(out_valid == 0, "R7 no valid after reset", out_valid, 0);
    chk(out_eob == 1, "R5 eob forced while disabled", out_eob, 1);
  endtask

  task automatic t_full_frame;
    @(negedge clk); proc_en = 1; ocnt = 0;
    @(negedge clk); #3;
    chk(rx_ready == 1, "R1 ready when enabled and idle", rx_ready, 1);
    send(FL, 1, 1);
    #3;
    chk(rx_ready == 0, "R2 ready low after full frame", rx_ready, 0);
    check_frame(1, "full frame with eob (R4 normal completion)");
  endtask

  task automatic t_partial_discard;
    ocnt = 0;
    send(600, 2, 1);
    repeat (60) @(negedge clk);
    #3;
    chk(ocnt == 0, "R4 partial frame produced no words", ocnt, 0);
    chk(rx_ready == 1, "R4 ready stays high after discard", rx_ready, 1);
    send(FL, 3, 0);
    check_frame(3, "frame after discard");
  endtask

  task automatic t_backpressure;
    ocnt = 0; hold_bad = 0; r1_bad = 0; bp_on = 1;
    send(FL, 4, 0);
    check_frame(4, "under back-pressure");
    bp_on = 0;
    @(negedge clk); out_ready = 1;
    chk(hold_bad == 0, "R10 word held while stalled", hold_bad, 0);
    chk(r1_bad == 0, "R1 ready gated by downstream ready", r1_bad, 0);
  endtask

  task automatic t_disable;
    int t, vbad;
    ocnt = 0; t = 0; vbad = 0;
    send(FL, 5, 0);
    while (ocnt < 300 && t < 20000) begin @(negedge clk); t++; end
    proc_en = 0;
    #1;
    chk(rx_ready == 0, "R1 ready drops with enable", rx_ready, 0);
    @(negedge clk); #3;
    chk(out_valid == 0, "R7 valid drops after disable", out_valid, 0);
    chk(out_eob == 1, "R5 eob forced after disable", out_eob, 1);
    chk(eng_flush == 1, "R5 engine flushed while disabled", eng_flush, 1);
    for (int i = 0; i < 8; i++) begin @(negedge clk); #3; if (out_valid) vbad++; end
    chk(vbad == 0, "R7 no valid while disabled", vbad, 0);
    ocnt = 0;
    proc_en = 1;
    repeat (40) @(negedge clk);
    #3;
    chk(ocnt == 0, "R5 no stale words after re-enable", ocnt, 0);
    send(FL, 6, 1);
    check_frame(6, "after re-enable");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    t_reset();
    t_full_frame();
    t_partial_discard();
    t_backpressure();
    t_disable();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule